// File: doc/BRIEF.md
# Whole-Frame Receive Packet Buffer

This block sits between a receive frame parser and a slower consumer, such as a DMA write engine. Both sides are byte-wide AXI4-Stream links, and `tlast` closes each Ethernet frame. Incoming bytes are written into a circular byte store under a tentative write pointer. A frame becomes visible to the reader only when its last byte arrives without trouble. At that point the tentative pointer is committed.

An Ethernet receiver cannot be stalled, so the input is always ready and storage pressure is handled only by dropping. There are two drop causes:
- an error flag on any byte of a frame;
- running out of room.

In either case the tentative pointer is rolled back to the last committed position. The remainder of the frame is then swallowed up to its `tlast`. Frames already stored are never disturbed. The reader therefore sees only complete, uncorrupted frames, in arrival order, even if it starts reading while a later frame is still coming in.

Two status outputs are provided: the number of complete frames waiting, and a saturating count of dropped frames.

Top module: `rx_packet_fifo`

## Requirements
- R1: During and right after reset, `m_tvalid` is 0, `frame_count` is 0, `drop_count` is 0 and `s_tready` is 1.
- R2: `s_tready` is 1 in every cycle; the input is never back-pressured.
- R3: `m_tvalid` is 1 exactly when at least one fully received, accepted frame is waiting. A frame whose `tlast` has not yet been accepted never raises `m_tvalid`.
- R4: Accepted frames leave in arrival order. Every byte appears on `m_tdata`, and `m_tlast` is 1 only on each frame's final byte.
- R5: A frame with `s_tuser`=1 on any of its beats (error marker) is discarded entirely and counts as one drop.
- R6: A beat arriving while the store holds DEPTH bytes (committed plus partial) discards its whole frame through `tlast`. Frames already stored stay intact, and the drop is counted once, on that frame's `tlast` beat. A frame longer than DEPTH is always discarded.
- R7: `drop_count` saturates at 2^CNT_W-1.
- R8: `frame_count` is the number of committed frames not yet fully read. It rises the cycle after a committing `tlast` and falls the cycle after the final byte of a frame is taken. It never exceeds DEPTH.
- R9: While `m_tvalid`=1 and `m_tready`=0, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R10: A frame of exactly DEPTH bytes written into an empty store is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | DATA_W | Incoming frame byte |
| s_tvalid | input | 1 | Incoming byte valid |
| s_tlast | input | 1 | Final byte of incoming frame |
| s_tuser | input | 1 | Error marker for the incoming frame |
| s_tready | output | 1 | Always 1 |
| m_tdata | output | DATA_W | Outgoing frame byte |
| m_tvalid | output | 1 | A complete frame is available |
| m_tlast | output | 1 | Final byte of outgoing frame |
| m_tready | input | 1 | Consumer accepts the byte |
| frame_count | output | log2(DEPTH)+1 | Complete frames waiting |
| drop_count | output | CNT_W | Saturating dropped-frame count |

## Verification
The bench runs one directed frame that is read while still arriving. A design that leaks partial frames would raise `m_tvalid` before that frame's `tlast`. It then fills the store with a frame of exactly DEPTH bytes and follows it with one more frame. An off-by-one full test would reject the first frame or corrupt it with the second. It also sends an error-marked frame and a frame longer than the store. A design that rolls back badly would emit stray bytes or miscount the drop, and random traffic with a stalling reader then drives `drop_count` into saturation, where a wrapping counter would fall back to zero.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;

   typedef enum logic {
      WR_PASS    = 1'b0,
      WR_DISCARD = 1'b1
   } wr_mode_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rxpf_store.sv
module rxpf_store #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 4096
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [WIDTH-1:0]         wdata,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [WIDTH-1:0]         rdata
);
   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/rxpf_write.sv
module rxpf_write
   import rxpf_pkg::*;
#(
   parameter int DEPTH = 4096,
   parameter int CNT_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   in_last,
   input  logic                   in_err,
   input  logic [$clog2(DEPTH):0] rd_ptr,
   output logic                   we,
   output logic [$clog2(DEPTH)-1:0] waddr,
   output logic                   commit,
   output logic [CNT_W-1:0]       drops
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0]    FULL_LVL = PW'(DEPTH);
   localparam logic [CNT_W-1:0] DROP_MAX = '1;

   logic [PW-1:0]    spec_q;
   logic [PW-1:0]    base_q;
   wr_mode_e         mode_q;
   logic [CNT_W-1:0] drops_q;
   logic             full;
   logic             reject;

   assign full   = (spec_q - rd_ptr) == FULL_LVL;
   assign reject = (mode_q == WR_DISCARD) || full || in_err;
   assign we     = in_valid && !reject;
   assign waddr  = spec_q[AW-1:0];
   assign commit = we && in_last;
   assign drops  = drops_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spec_q  <= '0;
         base_q  <= '0;
         mode_q  <= WR_PASS;
         drops_q <= '0;
      end else if (in_valid) begin
         if (!reject) begin
            spec_q <= spec_q + 1'b1;
            if (in_last) base_q <= spec_q + 1'b1;
         end else begin
            spec_q <= base_q;
            if (in_last) begin
               mode_q <= WR_PASS;
               if (drops_q != DROP_MAX) drops_q <= drops_q + 1'b1;
            end else begin
               mode_q <= WR_DISCARD;
            end
         end
      end
   end
endmodule

// File: rtl/rxpf_read.sv
module rxpf_read #(
   parameter int DEPTH = 4096
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   commit,
   input  logic                   cell_last,
   input  logic                   out_ready,
   output logic                   out_valid,
   output logic [$clog2(DEPTH):0] rd_ptr,
   output logic [$clog2(DEPTH):0] frames
);
   localparam int PW = $clog2(DEPTH) + 1;

   logic [PW-1:0] rd_q;
   logic [PW-1:0] frames_q;
   logic          take;
   logic          frame_done;

   assign out_valid  = frames_q != '0;
   assign take       = out_valid && out_ready;
   assign frame_done = take && cell_last;
   assign rd_ptr     = rd_q;
   assign frames     = frames_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q     <= '0;
         frames_q <= '0;
      end else begin
         if (take) rd_q <= rd_q + 1'b1;
         case ({commit, frame_done})
            2'b10:   frames_q <= frames_q + 1'b1;
            2'b01:   frames_q <= frames_q - 1'b1;
            default: frames_q <= frames_q;
         endcase
      end
   end
endmodule

// File: rtl/rx_packet_fifo.sv
module rx_packet_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4096,
   parameter int CNT_W  = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [DATA_W-1:0]      s_tdata,
   input  logic                   s_tvalid,
   input  logic                   s_tlast,
   input  logic                   s_tuser,
   output logic                   s_tready,
   output logic [DATA_W-1:0]      m_tdata,
   output logic                   m_tvalid,
   output logic                   m_tlast,
   input  logic                   m_tready,
   output logic [$clog2(DEPTH):0] frame_count,
   output logic [CNT_W-1:0]       drop_count
);
   localparam int AW     = $clog2(DEPTH);
   localparam int PW     = AW + 1;
   localparam int CELL_W = DATA_W + 1;

   generate
      if (!rxpf_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("rx_packet_fifo: DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_packet_fifo: DATA_W must be positive");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("rx_packet_fifo: CNT_W must be positive");
      end
   endgenerate

   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic              wr_commit;
   logic [PW-1:0]     rd_ptr;
   logic [CELL_W-1:0] rd_cell;

   assign s_tready = 1'b1;

   rxpf_write #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_write (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (s_tvalid),
      .in_last  (s_tlast),
      .in_err   (s_tuser),
      .rd_ptr   (rd_ptr),
      .we       (wr_en),
      .waddr    (wr_addr),
      .commit   (wr_commit),
      .drops    (drop_count)
   );

   rxpf_store #(.WIDTH(CELL_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata ({s_tlast, s_tdata}),
      .raddr (rd_ptr[AW-1:0]),
      .rdata (rd_cell)
   );

   rxpf_read #(.DEPTH(DEPTH)) u_read (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (wr_commit),
      .cell_last (rd_cell[DATA_W]),
      .out_ready (m_tready),
      .out_valid (m_tvalid),
      .rd_ptr    (rd_ptr),
      .frames    (frame_count)
   );

   assign m_tdata = rd_cell[DATA_W-1:0];
   assign m_tlast = rd_cell[DATA_W];
endmodule

// File: rtl/rx_packet_fifo_chk.sv
module rx_packet_fifo_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4096,
   parameter int CNT_W  = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   s_tvalid,
   input logic                   s_tlast,
   input logic                   s_tready,
   input logic [DATA_W-1:0]      m_tdata,
   input logic                   m_tvalid,
   input logic                   m_tlast,
   input logic                   m_tready,
   input logic [$clog2(DEPTH):0] frame_count,
   input logic [CNT_W-1:0]       drop_count
);
   localparam logic [CNT_W-1:0]         DMAX = '1;
   localparam logic [$clog2(DEPTH):0]   FMAX = ($clog2(DEPTH)+1)'(DEPTH);

   p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      s_tready);

   p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(m_tvalid) |-> $past(s_tvalid && s_tlast));

   p_drop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (drop_count == $past(drop_count)) ||
               (drop_count == $past(drop_count) + 1'b1));

   p_drop_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drop_count == DMAX |=> drop_count == DMAX);

   p_frame_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (frame_count == $past(frame_count)) ||
               (frame_count == $past(frame_count) + 1'b1) ||
               (frame_count == $past(frame_count) - 1'b1));

   p_frame_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_count <= FMAX);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));
endmodule

bind rx_packet_fifo rx_packet_fifo_chk #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/sim_rx_packet_fifo.sv
module sim_rx_packet_fifo;
   localparam int DEPTH = 64;
   localparam int CNT_W = 3;
   localparam int FW    = $clog2(DEPTH) + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [7:0]       s_tdata = '0;
   logic             s_tvalid = 1'b0;
   logic             s_tlast = 1'b0;
   logic             s_tuser = 1'b0;
   logic             s_tready;
   logic [7:0]       m_tdata;
   logic             m_tvalid;
   logic             m_tlast;
   logic             m_tready = 1'b0;
   logic [FW-1:0]    frame_count;
   logic [CNT_W-1:0] drop_count;

   always #2.5 clk = ~clk;

   rx_packet_fifo #(.DATA_W(8), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (.*);

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // reference model state
   logic [8:0] stored_q[$];
   logic [8:0] part_q[$];
   int  exp_frames = 0;
   int  exp_drop   = 0;
   bit  discarding = 0;
   bit  stalled    = 0;

   // generator controls
   bit  run = 0;
   int  quota = 0;
   int  len_min = 1, len_max = 1;
   int  gap_pct = 0, err_pct = 0, rd_pct = 0;
   int  gen_left = 0, gen_idx = 0, gen_err_at = -1;

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
      end
   endtask

   function automatic int drop_next(input int d);
      return (d == (1 << CNT_W) - 1) ? d : d + 1;
   endfunction

   always @(negedge clk) begin
      if (run) begin
         bit rd_now, rd_do, v, l, e;
         cyc++;
         if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
         // compare outputs settled after the last rising edge
         chk(s_tready === 1'b1, "R2 s_tready", int'(s_tready), 1);
         chk(m_tvalid === (exp_frames != 0), "R3 m_tvalid", int'(m_tvalid), int'(exp_frames != 0));
         chk(int'(frame_count) == exp_frames, "R8 frame_count", int'(frame_count), exp_frames);
         chk(int'(drop_count) == exp_drop, "R5/R6/R7 drop_count", int'(drop_count), exp_drop);
         if (exp_frames != 0)
            chk({m_tlast, m_tdata} === stored_q[0], stalled ? "R9 held byte" : "R4 byte/tlast",
                int'({m_tlast, m_tdata}), int'(stored_q[0]));
         // next stimulus
         if (gen_left == 0 && quota != 0) begin
            gen_left   = len_min + int'($urandom % (len_max - len_min + 1));
            gen_idx    = 0;
            gen_err_at = (int'($urandom % 100) < err_pct) ? int'($urandom % gen_left) : -1;
            if (quota > 0) quota--;
         end
         v = (gen_left > 0) && (int'($urandom % 100) >= gap_pct);
         l = 1'b0; e = 1'b0;
         if (v) begin
            l = (gen_left == 1);
            e = (gen_idx == gen_err_at);
            s_tdata = 8'($urandom);
            gen_left--; gen_idx++;
         end
         s_tvalid = v; s_tlast = l; s_tuser = e;
         rd_now   = int'($urandom % 100) < rd_pct;
         m_tready = rd_now;
         // model the coming edge: write side sees pre-read occupancy
         rd_do = (exp_frames != 0) && rd_now;
         if (v) begin
            if (discarding || e || (stored_q.size() + part_q.size() == DEPTH)) begin
               part_q.delete();
               if (l) begin discarding = 0; exp_drop = drop_next(exp_drop); end
               else discarding = 1;
            end else begin
               part_q.push_back({l, s_tdata});
               if (l) begin
                  foreach (part_q[k]) stored_q.push_back(part_q[k]);
                  part_q.delete();
                  exp_frames++;
               end
            end
         end
         if (rd_do) begin
            if (stored_q[0][8]) exp_frames--;
            void'(stored_q.pop_front());
         end
         stalled = (exp_frames != 0) && !rd_do;
      end
   end

   task automatic wait_gen_idle();
      while (!(gen_left == 0 && quota == 0)) @(negedge clk);
      repeat (2) @(negedge clk);
      #1;
   endtask

   task automatic drain();
      quota = 0; rd_pct = 100;
      wait_gen_idle();
      while (exp_frames != 0 || part_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      #1;
   endtask

   initial begin
      int d0;
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      #1;
      chk(m_tvalid == 1'b0, "R1 reset m_tvalid", int'(m_tvalid), 0);
      chk(frame_count == '0, "R1 reset frame_count", int'(frame_count), 0);
      chk(drop_count == '0, "R1 reset drop_count", int'(drop_count), 0);
      chk(s_tready == 1'b1, "R1 reset s_tready", int'(s_tready), 1);
      @(negedge clk); rst_n = 1'b1; run = 1;

      // R3: reader is ready while a 20-byte frame streams in
      rd_pct = 100; gap_pct = 0; err_pct = 0; len_min = 20; len_max = 20; quota = 1;
      repeat (10) @(negedge clk);
      #1;
      chk(m_tvalid == 1'b0, "R3 partial frame hidden", int'(m_tvalid), 0);
      drain();

      // R10: exactly DEPTH bytes into an empty store with the reader stopped
      rd_pct = 0; len_min = DEPTH; len_max = DEPTH; quota = 1;
      d0 = exp_drop;
      wait_gen_idle();
      chk(int'(frame_count) == 1, "R10 full-size frame stored", int'(frame_count), 1);
      chk(int'(drop_count) == d0, "R10 no drop", int'(drop_count), d0);
      // R6: store full, next frame must be dropped whole
      len_min = 5; len_max = 5; quota = 1;
      wait_gen_idle();
      chk(int'(drop_count) == d0 + 1, "R6 overflow drop", int'(drop_count), d0 + 1);
      chk(int'(frame_count) == 1, "R6 stored frame kept", int'(frame_count), 1);
      drain();

      // R5: error-marked frame, then a clean one
      d0 = exp_drop;
      rd_pct = 0; err_pct = 100; len_min = 10; len_max = 10; quota = 1;
      wait_gen_idle();
      chk(int'(drop_count) == d0 + 1, "R5 error frame dropped", int'(drop_count), d0 + 1);
      chk(int'(frame_count) == 0, "R5 nothing stored", int'(frame_count), 0);
      err_pct = 0; len_min = 7; len_max = 7; quota = 1;
      wait_gen_idle();
      chk(int'(frame_count) == 1, "R5 clean frame after error", int'(frame_count), 1);
      drain();

      // R6: frame longer than the store
      d0 = exp_drop;
      rd_pct = 100; len_min = DEPTH + 6; len_max = DEPTH + 6; quota = 1;
      wait_gen_idle();
      chk(int'(drop_count) == d0 + 1, "R6 oversize frame dropped", int'(drop_count), d0 + 1);
      chk(int'(frame_count) == 0, "R6 oversize not stored", int'(frame_count), 0);

      // random traffic, slow reader
      rd_pct = 25; gap_pct = 10; err_pct = 10; len_min = 1; len_max = 40; quota = -1;
      repeat (4000) @(negedge clk);
      drain();
      // random traffic, fast reader, some oversize frames
      rd_pct = 90; gap_pct = 30; err_pct = 5; len_min = 1; len_max = 80; quota = -1;
      repeat (4000) @(negedge clk);
      drain();

      chk(int'(drop_count) == (1 << CNT_W) - 1, "R7 drop counter saturated",
          int'(drop_count), (1 << CNT_W) - 1);
      run = 0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule